// File: doc/BRIEF.md
# Strip-Walking GF(2) Matrix Product Engine

This block computes C = A·B for two square N×N bit matrices, with arithmetic over GF(2): a product term is an AND and a sum is an XOR. It does not need either operand in full. The host supplies the product one strip at a time. Each strip pairs K consecutive columns of A with the K matching rows of B. The engine forms the full N×N partial product of that pair and XORs it into an on-chip N×N result store. Summing these partial products over all N/K strips gives the complete product.

Inside each strip, a tile engine of T×T parallel dot-product units builds one T×T output tile per clock. The controller visits the output tiles in row-major order. A strip therefore costs (N/T)² cycles of compute. The host loads strips through two small write ports into local buffers. It waits for a request output, fills both buffers and then acknowledges. When the last strip has been folded in, a done flag rises. The host then reads the result row by row.

Top module: `gf2_strip_mul`

## Requirements
- R1: After reset, `busy`, `done` and `strip_need` are all low.
- R2: A `start` pulse while idle or done clears the whole result store. On the next cycle `strip_need` is high and `strip_idx` is 0.
- R3: A-strip format: a write with `a_we` high stores `a_bits` as row `a_row` of the A buffer. Bit k of that row holds A[a_row][s·K+k] for strip s.
- R4: B-strip format: a write with `b_we` high stores `b_bits` as row `b_row` of the B buffer. Bit c of that row holds B[s·K+b_row][c].
- R5: After all N/K strips, result row r bit c equals the XOR over k of (A[r][k] AND B[k][c]). Identity and zero operands give B, A or the zero matrix as that formula predicts.
- R6: `done` rises after the last tile of strip N/K−1 and stays high until the next `start`.
- R7: A `start` pulse while `busy` is high is ignored. It does not change the strip sequence, the timing or the result.
- R8: `strip_need` and `strip_idx` hold steady until `strip_ready` is seen. A `strip_ready` pulse while no strip is requested has no effect.
- R9: `rd_bits` presents result row `rd_row` one clock after `rd_row` is applied.
- R10: Each output tile takes exactly one cycle. `strip_need` (or `done`) returns exactly (N/T)² cycles after the edge that accepts `strip_ready`.
- R11: A restart from done produces a fresh product with no trace of the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new product (honoured only when idle or done) |
| busy | output | 1 | Product in progress |
| done | output | 1 | Product complete; held until next start |
| strip_need | output | 1 | Engine is waiting for strip `strip_idx` |
| strip_idx | output | max(1,clog2(N/K)) | Index of the strip being requested |
| strip_ready | input | 1 | Both strip buffers are filled for the requested strip |
| a_we | input | 1 | A-buffer write enable |
| a_row | input | max(1,clog2(N)) | A-buffer row address |
| a_bits | input | K | A-strip row data |
| b_we | input | 1 | B-buffer write enable |
| b_row | input | max(1,clog2(K)) | B-buffer row address |
| b_bits | input | N | B-strip row data |
| rd_row | input | max(1,clog2(N)) | Result row to read |
| rd_bits | output | N | Registered result row |

## Verification
The bench builds the block with N=24, K=6 and T=4. That gives four strips and a 6×6 grid of tiles per strip. Because K is not a multiple of T, every strip contributes a piece to every tile. A fault in the strip-to-row or tile-to-column mapping therefore corrupts results that a reference product will catch. The size also keeps the 36-cycle tile walk short enough to inject stray `start` and `strip_ready` pulses in the middle of it.

// File: rtl/gf2_mm_pkg.sv
package gf2_mm_pkg;

  typedef enum logic [1:0] {
    MM_IDLE = 2'd0,
    MM_WAIT = 2'd1,
    MM_RUN  = 2'd2,
    MM_DONE = 2'd3
  } mm_state_e;

  // address width of at least one bit
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/gf2_strip_buf.sv
module gf2_strip_buf #(
  parameter int ROWS = 24,
  parameter int W    = 6,
  localparam int AW  = gf2_mm_pkg::idx_width(ROWS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [W-1:0]             wdata,
  output logic [ROWS-1:0][W-1:0]   rows
);

  logic [ROWS-1:0][W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (we && (int'(waddr) < ROWS)) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rows = mem_q;

endmodule

// File: rtl/gf2_tile_engine.sv
module gf2_tile_engine #(
  parameter int N   = 24,
  parameter int K   = 6,
  parameter int T   = 4,
  localparam int M  = N / T,
  localparam int MW = gf2_mm_pkg::idx_width(M)
) (
  input  logic [N-1:0][K-1:0] a_rows,
  input  logic [K-1:0][N-1:0] b_rows,
  input  logic [MW-1:0]       tile_r,
  input  logic [MW-1:0]       tile_c,
  output logic [T*T-1:0]      tile_bits
);

  // one GF(2) dot product: AND then XOR-reduce
  function automatic logic gf2_dot(input logic [K-1:0] x, input logic [K-1:0] y);
    return ^(x & y);
  endfunction

  logic [T-1:0][K-1:0] a_sel;
  logic [T-1:0][K-1:0] b_sel;

  for (genvar i = 0; i < T; i++) begin : g_arow
    always_comb begin
      a_sel[i] = a_rows[int'(tile_r) * T + i];
    end
  end

  for (genvar j = 0; j < T; j++) begin : g_bcol
    for (genvar k = 0; k < K; k++) begin : g_bk
      always_comb begin
        b_sel[j][k] = b_rows[k][int'(tile_c) * T + j];
      end
    end
  end

  for (genvar i = 0; i < T; i++) begin : g_ui
    for (genvar j = 0; j < T; j++) begin : g_uj
      assign tile_bits[i*T + j] = gf2_dot(a_sel[i], b_sel[j]);
    end
  end

endmodule

// File: rtl/gf2_accum_store.sv
module gf2_accum_store #(
  parameter int N   = 24,
  parameter int T   = 4,
  localparam int M  = N / T,
  localparam int MW = gf2_mm_pkg::idx_width(M),
  localparam int AW = gf2_mm_pkg::idx_width(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             acc_we,
  input  logic [MW-1:0]    tile_r,
  input  logic [MW-1:0]    tile_c,
  input  logic [T*T-1:0]   tile_bits,
  input  logic [AW-1:0]    rd_row,
  output logic [N-1:0]     rd_bits
);

  logic [N-1:0][N-1:0] acc_q;
  logic [N-1:0]        row_hit;
  logic [N-1:0]        col_hit;

  for (genvar r = 0; r < N; r++) begin : g_rhit
    assign row_hit[r] = (int'(tile_r) == (r / T));
  end
  for (genvar c = 0; c < N; c++) begin : g_chit
    assign col_hit[c] = (int'(tile_c) == (c / T));
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q[r][c] <= 1'b0;
        end else if (clear) begin
          acc_q[r][c] <= 1'b0;
        end else if (acc_we && row_hit[r] && col_hit[c]) begin
          acc_q[r][c] <= acc_q[r][c] ^ tile_bits[(r % T)*T + (c % T)];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bits <= '0;
    end else if (int'(rd_row) < N) begin
      rd_bits <= acc_q[rd_row];
    end else begin
      rd_bits <= '0;
    end
  end

  // R11
  clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> !clear);

endmodule

// File: rtl/gf2_strip_ctrl.sv
module gf2_strip_ctrl #(
  parameter int N   = 24,
  parameter int K   = 6,
  parameter int T   = 4,
  localparam int S  = N / K,
  localparam int M  = N / T,
  localparam int SW = gf2_mm_pkg::idx_width(S),
  localparam int MW = gf2_mm_pkg::idx_width(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          strip_ready,
  output logic          busy,
  output logic          done,
  output logic          strip_need,
  output logic [SW-1:0] strip_idx,
  output logic          clear_evt,
  output logic          acc_we,
  output logic [MW-1:0] tile_r,
  output logic [MW-1:0] tile_c
);
  import gf2_mm_pkg::*;

  mm_state_e     state_q;
  logic [SW-1:0] strip_q;
  logic [MW-1:0] tr_q, tc_q;

  logic start_evt, accept_evt, row_end, last_tile, last_strip;

  assign start_evt  = start && (state_q == MM_IDLE || state_q == MM_DONE);
  assign accept_evt = (state_q == MM_WAIT) && strip_ready;
  assign row_end    = (tc_q == MW'(M-1));
  assign last_tile  = (state_q == MM_RUN) && row_end && (tr_q == MW'(M-1));
  assign last_strip = (strip_q == SW'(S-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MM_IDLE;
      strip_q <= '0;
      tr_q    <= '0;
      tc_q    <= '0;
    end else begin
      unique case (state_q)
        MM_IDLE, MM_DONE: begin
          if (start) begin
            state_q <= MM_WAIT;
            strip_q <= '0;
            tr_q    <= '0;
            tc_q    <= '0;
          end
        end
        MM_WAIT: begin
          if (strip_ready) state_q <= MM_RUN;
        end
        MM_RUN: begin
          if (row_end) begin
            tc_q <= '0;
            if (tr_q == MW'(M-1)) begin
              tr_q <= '0;
              if (last_strip) begin
                state_q <= MM_DONE;
              end else begin
                state_q <= MM_WAIT;
                strip_q <= strip_q + SW'(1);
              end
            end else begin
              tr_q <= tr_q + MW'(1);
            end
          end else begin
            tc_q <= tc_q + MW'(1);
          end
        end
        default: state_q <= MM_IDLE;
      endcase
    end
  end

  assign busy       = (state_q == MM_WAIT) || (state_q == MM_RUN);
  assign done       = (state_q == MM_DONE);
  assign strip_need = (state_q == MM_WAIT);
  assign strip_idx  = strip_q;
  assign clear_evt  = start_evt;
  assign acc_we     = (state_q == MM_RUN);
  assign tile_r     = tr_q;
  assign tile_c     = tc_q;

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_tile));

  // R8
  need_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strip_need && !strip_ready |=> strip_need && $stable(strip_idx));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> (busy || done) && (strip_idx >= $past(strip_idx)));

  // R10
  tile_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> (int'(tile_r) < M) && (int'(tile_c) < M));

  // R2
  strip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(strip_idx) < S);

  // R1
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

endmodule

// File: rtl/gf2_strip_mul.sv
module gf2_strip_mul #(
  parameter int N    = 24,
  parameter int K    = 6,
  parameter int T    = 4,
  localparam int S   = N / K,
  localparam int M   = N / T,
  localparam int SW  = gf2_mm_pkg::idx_width(S),
  localparam int MW  = gf2_mm_pkg::idx_width(M),
  localparam int ANW = gf2_mm_pkg::idx_width(N),
  localparam int AKW = gf2_mm_pkg::idx_width(K)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           strip_need,
  output logic [SW-1:0]  strip_idx,
  input  logic           strip_ready,
  input  logic           a_we,
  input  logic [ANW-1:0] a_row,
  input  logic [K-1:0]   a_bits,
  input  logic           b_we,
  input  logic [AKW-1:0] b_row,
  input  logic [N-1:0]   b_bits,
  input  logic [ANW-1:0] rd_row,
  output logic [N-1:0]   rd_bits
);

  logic [N-1:0][K-1:0] a_rows;
  logic [K-1:0][N-1:0] b_rows;
  logic                clear_evt, acc_we;
  logic [MW-1:0]       tile_r, tile_c;
  logic [T*T-1:0]      tile_bits;

  gf2_strip_buf #(.ROWS(N), .W(K)) u_abuf (
    .clk(clk), .rst_n(rst_n), .we(a_we), .waddr(a_row),
    .wdata(a_bits), .rows(a_rows)
  );

  gf2_strip_buf #(.ROWS(K), .W(N)) u_bbuf (
    .clk(clk), .rst_n(rst_n), .we(b_we), .waddr(b_row),
    .wdata(b_bits), .rows(b_rows)
  );

  gf2_strip_ctrl #(.N(N), .K(K), .T(T)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .strip_ready(strip_ready),
    .busy(busy), .done(done), .strip_need(strip_need),
    .strip_idx(strip_idx), .clear_evt(clear_evt), .acc_we(acc_we),
    .tile_r(tile_r), .tile_c(tile_c)
  );

  gf2_tile_engine #(.N(N), .K(K), .T(T)) u_eng (
    .a_rows(a_rows), .b_rows(b_rows), .tile_r(tile_r), .tile_c(tile_c),
    .tile_bits(tile_bits)
  );

  gf2_accum_store #(.N(N), .T(T)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(clear_evt), .acc_we(acc_we),
    .tile_r(tile_r), .tile_c(tile_c), .tile_bits(tile_bits),
    .rd_row(rd_row), .rd_bits(rd_bits)
  );

  initial begin
    // R10
    shape_ok_chk: assert ((N % K == 0) && (N % T == 0) && (T >= 1) && (K >= 1));
  end

endmodule

// File: tb/gf2_strip_mul_bench.sv
module gf2_strip_mul_bench;

  localparam int N   = 24;
  localparam int K   = 6;
  localparam int T   = 4;
  localparam int S   = N / K;
  localparam int M   = N / T;
  localparam int SW  = (S > 1) ? $clog2(S) : 1;
  localparam int ANW = (N > 1) ? $clog2(N) : 1;
  localparam int AKW = (K > 1) ? $clog2(K) : 1;
  localparam int NCASE = 6;
  // stimulus table: kind (0 random, 1 identity A, 2 zero B, 3 identity both,
  // 4 all-ones A, 5 sparse both), seed, stray-pulse injection (0 none, 1 start, 2 ready)
  localparam int CASE_KIND [NCASE] = '{0, 1, 2, 3, 4, 5};
  localparam int CASE_SEED [NCASE] = '{32'h1234_5678, 32'h0bad_cafe, 32'h5eed_0001,
                                        32'h0000_0007, 32'h7777_1111, 32'h2468_ace1};
  localparam int CASE_INJ  [NCASE] = '{1, 0, 2, 0, 0, 0};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0, strip_ready = 1'b0;
  logic           busy, done, strip_need;
  logic [SW-1:0]  strip_idx;
  logic           a_we = 1'b0, b_we = 1'b0;
  logic [ANW-1:0] a_row = '0;
  logic [K-1:0]   a_bits = '0;
  logic [AKW-1:0] b_row = '0;
  logic [N-1:0]   b_bits = '0;
  logic [ANW-1:0] rd_row = '0;
  logic [N-1:0]   rd_bits;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [N-1:0] ma [N];
  logic [N-1:0] mb [N];
  logic [N-1:0] mc [N];
  logic [31:0]  rng;

  always #10 clk = ~clk;

  gf2_strip_mul #(.N(N), .K(K), .T(T)) u_gf2_strip_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .strip_need(strip_need), .strip_idx(strip_idx), .strip_ready(strip_ready),
    .a_we(a_we), .a_row(a_row), .a_bits(a_bits), .b_we(b_we), .b_row(b_row),
    .b_bits(b_bits), .rd_row(rd_row), .rd_bits(rd_bits)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13;
    y ^= y >> 17;
    y ^= y << 5;
    return y;
  endfunction

  task automatic build(input int kind, input int seed);
    rng = seed;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        rng = next_rand(rng);
        ma[r][c] = rng[3];
        rng = next_rand(rng);
        mb[r][c] = rng[7];
        if (kind == 5) begin
          ma[r][c] = ma[r][c] & rng[11] & rng[12];
          mb[r][c] = mb[r][c] & rng[19] & rng[20];
        end
      end
      if (kind == 1 || kind == 3) ma[r] = '0;
      if (kind == 2) mb[r] = '0;
      if (kind == 3) mb[r] = '0;
      if (kind == 4) ma[r] = '1;
    end
    if (kind == 1 || kind == 3) for (int r = 0; r < N; r++) ma[r][r] = 1'b1;
    if (kind == 3) for (int r = 0; r < N; r++) mb[r][r] = 1'b1;
    // reference product: AND terms, XOR sums
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        logic acc = 1'b0;
        for (int k = 0; k < N; k++) acc ^= ma[r][k] & mb[k][c];
        mc[r][c] = acc;
      end
    end
  endtask

  task automatic run_product(input int inj);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: request for strip 0 one cycle after start
    check(strip_need && strip_idx == '0 && busy && !done, "R2",
          {strip_need, 7'(strip_idx)}, 64'h80);
    for (int s = 0; s < S; s++) begin
      int cnt = 0;
      check(strip_need && int'(strip_idx) == s, "R8 strip index", strip_idx, s);
      // R3 / R4: load strip s of A (columns) and B (rows)
      for (int r = 0; r < N; r++) begin
        a_we = 1'b1; a_row = ANW'(r);
        for (int k = 0; k < K; k++) a_bits[k] = ma[r][s*K + k];
        if (r < K) begin
          b_we = 1'b1; b_row = AKW'(r); b_bits = mb[s*K + r];
        end else b_we = 1'b0;
        @(negedge clk);
      end
      a_we = 1'b0; b_we = 1'b0;
      // R8: still waiting after the loads
      check(strip_need && int'(strip_idx) == s, "R8 hold", strip_idx, s);
      strip_ready = 1'b1;
      @(negedge clk);
      strip_ready = 1'b0;
      cnt = 1;
      while (!strip_need && !done) begin
        if (cnt == 3 && s == 1 && inj == 1) start = 1'b1;       // R7 stray start
        else if (cnt == 5 && s == 2 && inj == 2) strip_ready = 1'b1; // R8 stray ready
        @(negedge clk);
        start = 1'b0; strip_ready = 1'b0;
        cnt++;
        if (cnt > 4*M*M) break;
      end
      // R10: one tile per cycle
      check(cnt == M*M + 1, (inj != 0) ? "R10/R7/R8 strip cycles" : "R10 strip cycles",
            cnt, M*M + 1);
      if (s < S-1) check(strip_need && !done, "R6 early done", done, 0);
      else         check(done && !busy && !strip_need, "R6 done", done, 1);
    end
  endtask

  task automatic read_compare(input string req);
    int bad = 0;
    for (int r = 0; r < N; r++) begin
      rd_row = ANW'(r);
      @(negedge clk);
      // R9: registered read
      if (rd_bits !== mc[r]) begin
        if (bad == 0) check(1'b0, req, rd_bits, mc[r]);
        bad++;
      end
    end
    if (bad == 0) check(1'b1, req, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !strip_need, "R1", {busy, done, strip_need}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !strip_need, "R1 after release", {busy, done, strip_need}, 0);
    // R8: stray ready while idle does nothing
    strip_ready = 1'b1;
    @(negedge clk);
    strip_ready = 1'b0;
    @(negedge clk);
    check(!busy && !strip_need, "R8 idle ready", {busy, strip_need}, 0);

    for (int i = 0; i < NCASE; i++) begin
      build(CASE_KIND[i], CASE_SEED[i]);
      run_product(CASE_INJ[i]);
      read_compare("R5 product");
      if (CASE_KIND[i] == 1) begin
        bit same = 1'b1;
        for (int r = 0; r < N; r++) if (mc[r] !== mb[r]) same = 1'b0;
        check(same, "R5 identity gives B", same, 1);
      end
      // R6: done holds while no start
      repeat (4) @(negedge clk);
      check(done, "R6 hold", done, 1);
    end

    // R11: restart from done with zero operands wipes the previous result
    build(2, 32'h1357_9bdf);
    for (int r = 0; r < N; r++) ma[r] = '0;
    for (int r = 0; r < N; r++) mc[r] = '0;
    run_product(0);
    read_compare("R11 restart clears");

    // R3/R4 address sweep: identity both at a new seed
    build(3, 32'h0000_0042);
    run_product(0);
    read_compare("R5 identity squared");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule